// File: doc/BRIEF.md
# Supervisor Mode Trap Controller

This block decides when a 16-bit processor leaves user execution for supervisor execution and when it comes back. Two events cause entry: a decoded software trap instruction and a level-sensitive peripheral interrupt line. Both go to one fixed vector. On entry the block records the program counter of the interrupted instruction boundary in a dedicated saved-PC register and tells the program counter logic to load the vector. A decoded return instruction sends the program counter back to the saved value and restores user mode. While supervisor mode is active, every further trap and interrupt is masked. An interrupt that stays asserted is taken at the first instruction boundary after the return.

Supervisor code can read the saved-PC register into a general register and write it back, so a handler can inspect or change the return address. Instruction decode and the program counter register belong to the surrounding core. The core presents the decoded requests together with a `step_i` strobe that marks an instruction boundary. The override value and its load strobe come back in the same cycle, derived combinationally from the inputs and the held state. No data flows as a stream through this block, so every pin is a plain control or status pin with no valid/ready handshake and no back-pressure.

Top module: `svc_trap_ctl`

## Requirements
- R1: After reset `super_o` is 0 and the saved-PC register holds 0, so a read returns 0.
- R2: In user mode, with `step_i` high and either `trap_i` or `irq_i` high, `pc_load_o` is 1 and `pc_value_o` is 0x0002 in that cycle. After the clock edge `super_o` is 1 and the saved-PC register holds that cycle's `pc_i`.
- R3: When `trap_i` and `irq_i` are both high in the same qualifying cycle, exactly one entry takes place, with the same outputs and state as R2.
- R4: In supervisor mode, with `step_i` and `ret_i` high, `pc_load_o` is 1 and `pc_value_o` equals the saved-PC value held before that edge. After the edge `super_o` is 0.
- R5: In supervisor mode, `trap_i` and `irq_i` cause no load, leave the mode unchanged and leave the saved-PC register unchanged.
- R6: An `irq_i` held high through supervisor mode is not taken in the return cycle. It is taken at the first `step_i` cycle in user mode after the return.
- R7: When `step_i` is low, `trap_i`, `irq_i` and `ret_i` have no effect on the outputs, the mode or the saved-PC register.
- R8: A return request in user mode is ignored: no load and no mode change.
- R9: `epc_rdata_o` equals the saved-PC register while `epc_rd_i` is high, and is 0 otherwise. The path is combinational.
- R10: With `epc_wr_i` high, the saved-PC register takes `epc_wdata_i` at the clock edge in either mode. If an entry happens in the same cycle, the entry's save wins.
- R11: `pc_value_o` is 0 whenever `pc_load_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 16 | Program counter at the current boundary |
| trap_i | input | 1 | Decoded software trap request |
| ret_i | input | 1 | Decoded return-to-user request |
| irq_i | input | 1 | Peripheral interrupt level |
| epc_rd_i | input | 1 | Read request for the saved PC |
| epc_wr_i | input | 1 | Write request for the saved PC |
| epc_wdata_i | input | 16 | Value written into the saved PC |
| pc_load_o | output | 1 | Program counter override strobe |
| pc_value_o | output | 16 | Program counter override value |
| epc_rdata_o | output | 16 | Saved PC read data |
| super_o | output | 1 | 1 while supervisor mode is active |

## Verification
Several functions can land on the same cycle:
- the software trap and the peripheral interrupt;
- a return and a rewrite of the saved PC;
- an entry and a rewrite of the saved PC.

The bench sweeps every combination of boundary strobe, trap, interrupt, return, read and write, starting from each mode. It first brings the design into that mode and loads a known saved PC. It then checks the combinational outputs in the collision cycle, and the mode and saved PC one edge later. The expected values come from an arithmetic model of the priority rules. A directed sequence holds the interrupt across a handler to judge the deferral described in R6.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ENTER  = 2'd1,
    EV_RETURN = 2'd2
  } svc_event_e;
endpackage

// File: rtl/svc_event_sel.sv
module svc_event_sel
  import svc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       super_i,
  input  logic       trap_i,
  input  logic       irq_i,
  input  logic       ret_i,
  output svc_event_e ev_o
);
  logic want_enter;
  logic want_return;

  // Entry and return are mutually exclusive through the mode flag.
  assign want_enter  = step_i && !super_i && (trap_i || irq_i);
  assign want_return = step_i &&  super_i && ret_i;

  always_comb begin
    ev_o = EV_NONE;
    if (want_enter)       ev_o = EV_ENTER;
    else if (want_return) ev_o = EV_RETURN;
  end

  // Entry only from user mode (R5, R3: a single event per cycle)
  assert_enter_user_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o == EV_ENTER) |-> !super_i);
  // Return only from supervisor mode (R8)
  assert_return_super_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o == EV_RETURN) |-> super_i);
  // No event off an instruction boundary (R7)
  assert_boundary_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |-> (ev_o == EV_NONE));
endmodule

// File: rtl/svc_mode_reg.sv
module svc_mode_reg
  import svc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  svc_event_e ev_i,
  output logic       super_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  super_q <= 1'b0;
    else if (ev_i == EV_ENTER)   super_q <= 1'b1;
    else if (ev_i == EV_RETURN)  super_q <= 1'b0;
  end

  assert_enter_sets_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_ENTER) |=> super_q);
  assert_return_clears_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_RETURN) |=> !super_q);
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_NONE) |=> $stable(super_q));
endmodule

// File: rtl/svc_epc_reg.sv
module svc_epc_reg
  import svc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  svc_event_e      ev_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            wr_i,
  input  logic [PC_W-1:0] wdata_i,
  output logic [PC_W-1:0] epc_q
);
  // The entry save takes priority over a software write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 epc_q <= '0;
    else if (ev_i == EV_ENTER)  epc_q <= pc_i;
    else if (wr_i)              epc_q <= wdata_i;
  end

  assert_save_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_ENTER) |=> (epc_q == $past(pc_i)));
  assert_sw_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ev_i != EV_ENTER) |=> (epc_q == $past(wdata_i)));
  assert_epc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && ev_i != EV_ENTER) |=> $stable(epc_q));
endmodule

// File: rtl/svc_trap_ctl.sv
module svc_trap_ctl
  import svc_pkg::*;
#(
  parameter int unsigned      PC_W        = 16,
  parameter logic [PC_W-1:0]  TRAP_VECTOR = 16'h0002
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            trap_i,
  input  logic            ret_i,
  input  logic            irq_i,
  input  logic            epc_rd_i,
  input  logic            epc_wr_i,
  input  logic [PC_W-1:0] epc_wdata_i,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_value_o,
  output logic [PC_W-1:0] epc_rdata_o,
  output logic            super_o
);
  svc_event_e      ev;
  logic            super_q;
  logic [PC_W-1:0] epc_q;

  svc_event_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_i),
    .super_i (super_q),
    .trap_i  (trap_i),
    .irq_i   (irq_i),
    .ret_i   (ret_i),
    .ev_o    (ev)
  );

  svc_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .super_q (super_q)
  );

  svc_epc_reg #(.PC_W(PC_W)) u_epc (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .pc_i    (pc_i),
    .wr_i    (epc_wr_i),
    .wdata_i (epc_wdata_i),
    .epc_q   (epc_q)
  );

  // A return jumps to the value held before the edge, even when it is rewritten in that cycle.
  always_comb begin
    pc_load_o  = 1'b0;
    pc_value_o = '0;
    unique case (ev)
      EV_ENTER: begin
        pc_load_o  = 1'b1;
        pc_value_o = TRAP_VECTOR;
      end
      EV_RETURN: begin
        pc_load_o  = 1'b1;
        pc_value_o = epc_q;
      end
      default: ;
    endcase
  end

  assign epc_rdata_o = epc_rd_i ? epc_q : '0;
  assign super_o     = super_q;

  // Masking in supervisor mode (R5)
  assert_mask_in_super_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (super_o && !ret_i) |-> !pc_load_o);
  // Quiet override value (R11)
  assert_idle_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load_o |-> (pc_value_o == '0));
  // Loads from user mode always target the vector (R2)
  assert_vector_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !super_o) |-> (pc_value_o == TRAP_VECTOR));
  // A load from supervisor mode always flips the mode back (R4)
  assert_return_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && super_o) |=> !super_o);
endmodule

// File: tb/test_svc_trap_ctl.sv
module test_svc_trap_ctl;
  localparam int W = 16;
  localparam logic [W-1:0] VEC = 16'h0002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 0, trap_i = 0, ret_i = 0, irq_i = 0, epc_rd_i = 0, epc_wr_i = 0;
  logic [W-1:0] pc_i = '0, epc_wdata_i = '0;
  logic pc_load_o, super_o;
  logic [W-1:0] pc_value_o, epc_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  svc_trap_ctl i_svc_trap_ctl (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .pc_i(pc_i), .trap_i(trap_i),
    .ret_i(ret_i), .irq_i(irq_i), .epc_rd_i(epc_rd_i), .epc_wr_i(epc_wr_i),
    .epc_wdata_i(epc_wdata_i), .pc_load_o(pc_load_o), .pc_value_o(pc_value_o),
    .epc_rdata_o(epc_rdata_o), .super_o(super_o)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    step_i = 0; trap_i = 0; ret_i = 0; irq_i = 0; epc_rd_i = 0; epc_wr_i = 0;
    pc_i = '0; epc_wdata_i = '0;
  endtask

  // Drive at the falling edge, pass the next rising edge, stop 1 ns after it.
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic read_state(input string req, input logic exp_s, input logic [W-1:0] exp_epc);
    @(negedge clk); idle(); epc_rd_i = 1; #1;
    chk(req, "super_o", {15'd0, super_o}, {15'd0, exp_s});
    chk(req, "epc", epc_rdata_o, exp_epc);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    read_state("R1", 1'b0, '0);
    @(negedge clk); #1;
    chk("R9", "rdata without rd", epc_rdata_o, '0);

    // Sweep: start mode x step x trap x irq x ret x rd x wr (R2 R3 R4 R5 R7 R8 R9 R10 R11)
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 64; k++) begin
        logic s0, st, tr, iq, rt, rd, wr, en, rn, s1;
        logic [W-1:0] e0, p, w, e1, exp_val;
        s0 = m[0];
        {st, tr, iq, rt, rd, wr} = k[5:0];
        e0 = 16'h4000 + W'(k * 37 + m * 11);
        p  = 16'h8100 + W'(k * 5);
        w  = 16'hC000 + W'(k * 3 + m);
        do_reset();
        if (s0) begin
          @(negedge clk); idle(); step_i = 1; trap_i = 1; pc_i = 16'h1230; cyc();
        end
        @(negedge clk); idle(); epc_wr_i = 1; epc_wdata_i = e0; cyc();
        // collision cycle
        @(negedge clk); idle();
        step_i = st; trap_i = tr; irq_i = iq; ret_i = rt; epc_rd_i = rd;
        epc_wr_i = wr; epc_wdata_i = w; pc_i = p;
        #1;
        en = st && !s0 && (tr || iq);
        rn = st && s0 && rt;
        exp_val = en ? VEC : (rn ? e0 : '0);
        chk(en ? (tr && iq ? "R3" : "R2") : (rn ? "R4" : (s0 ? "R5" : (st ? "R8" : "R7"))),
            "pc_load_o", {15'd0, pc_load_o}, {15'd0, en || rn});
        chk(en || rn ? "R2" : "R11", "pc_value_o", pc_value_o, exp_val);
        chk("R9", "rdata", epc_rdata_o, rd ? e0 : '0);
        s1 = en ? 1'b1 : (rn ? 1'b0 : s0);
        e1 = en ? p : (wr ? w : e0);
        cyc();
        read_state(en ? "R2" : (wr ? "R10" : "R5"), s1, e1);
      end
    end

    // R6 pending interrupt held through a handler
    do_reset();
    @(negedge clk); idle(); step_i = 1; irq_i = 1; pc_i = 16'h0100; #1;
    chk("R6", "first entry load", {15'd0, pc_load_o}, 16'd1);
    cyc();
    @(negedge clk); idle(); step_i = 1; irq_i = 1; pc_i = 16'h0004; #1;
    chk("R6", "masked while super", {15'd0, pc_load_o}, 16'd0);
    cyc();
    @(negedge clk); idle(); step_i = 1; irq_i = 1; ret_i = 1; pc_i = 16'h0006; #1;
    chk("R6", "return value", pc_value_o, 16'h0100);
    cyc();
    chk("R6", "user after return", {15'd0, super_o}, 16'd0);
    @(negedge clk); idle(); step_i = 0; irq_i = 1; #1;
    chk("R6", "no entry off boundary", {15'd0, pc_load_o}, 16'd0);
    cyc();
    @(negedge clk); idle(); step_i = 1; irq_i = 1; pc_i = 16'h0100; #1;
    chk("R6", "re-entry value", pc_value_o, VEC);
    cyc();
    read_state("R6", 1'b1, 16'h0100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule